// File: doc/BRIEF.md
# Feedback Clock Divider with Three-Level Ratio Select

This block divides a fast input clock by one of nine ratios. Two select inputs choose the ratio, and each select stands for a pin with three levels: low, middle or high. The divided clock goes to a pair of identical outputs that are meant to close an external feedback loop. Every ratio gives a 50% duty cycle, and that includes the odd ratios. For an odd ratio the block combines a phase timed on the rising input edge with a copy of that phase delayed by half an input period on the falling edge.

The selects are configuration inputs, but a change to them is still handled cleanly. The active ratio is held in a register and is replaced only when a full output period has ended. No high or low phase is ever cut short. A select code that does not name a level raises a flag, and the divider then falls back to passing the input clock through unchanged.

Top module: `fbk_clock_divider`

## Requirements
- R1: Each select is coded 2'b00 = low, 2'b01 = middle, 2'b10 = high. The pair (sel_hi_i, sel_lo_i) picks the ratio as follows: low/low 1, low/mid 2, low/high 3, mid/low 4, mid/mid 5, mid/high 6, high/low 8, high/mid 10, high/high 12. An output at ratio N has a period of N input clock periods.
- R2: For an even ratio N, the output is high for N/2 input periods and low for N/2 input periods.
- R3: For ratio 3 or 5, the output is high for N half input periods and low for N half input periods, which is a 50% duty cycle.
- R4: At ratio 1, the output follows the input clock.
- R5: illegal_sel_o is high exactly when either select carries 2'b11. A load taken while the flag is high sets ratio 1.
- R6: All bits of fbk_clk_o carry the same waveform at all times.
- R7: While rst_ni is low, the outputs are low and the counter state is cleared. After reset is released, the first high phase starts on the first rising input edge.
- R8: A new select setting takes effect only at the end of the current output period, after its low phase has completed. Every period is a whole period of either the old ratio or the new one.
- R9: Every high phase of a divided output starts on a rising edge of the input clock, at counter value zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_hi_i | input | 2 | Upper three-level select (00 low, 01 mid, 10 high) |
| sel_lo_i | input | 2 | Lower three-level select (00 low, 01 mid, 10 high) |
| fbk_clk_o | output | NUM_OUT (2) | Matched divided clock outputs |
| illegal_sel_o | output | 1 | High when either select carries the unused code 2'b11 |

## Verification
The assertions assume three things. The input clock runs without interruption. Reset is asserted asynchronously and held for at least one rising edge. The selects are sampled only at rising edges, so a select change between edges is seen as one step. The stimulus changes selects only a few nanoseconds after a sampling point, well away from any clock edge. It releases reset while the input clock is low, so the first rising edge cleanly opens the first period. Each output is sampled once in every half input period. Because of this, every high and low phase, including the half-period steps of the odd ratios, is compared against a pattern that is built from the ratio alone.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int MAX_RATIO = 12;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } level_e;

    // Counter state: position inside the period, active ratio, rising-edge phase
    typedef struct packed {
        ratio_t cnt;
        ratio_t ratio;
        logic   pos;
    } phase_st_t;

    function automatic ratio_t ratio_of(input logic [1:0] hi, input logic [1:0] lo);
        ratio_t r;
        case ({hi, lo})
            {LVL_LOW,  LVL_LOW }: r = ratio_t'(1);
            {LVL_LOW,  LVL_MID }: r = ratio_t'(2);
            {LVL_LOW,  LVL_HIGH}: r = ratio_t'(3);
            {LVL_MID,  LVL_LOW }: r = ratio_t'(4);
            {LVL_MID,  LVL_MID }: r = ratio_t'(5);
            {LVL_MID,  LVL_HIGH}: r = ratio_t'(6);
            {LVL_HIGH, LVL_LOW }: r = ratio_t'(8);
            {LVL_HIGH, LVL_MID }: r = ratio_t'(10);
            {LVL_HIGH, LVL_HIGH}: r = ratio_t'(12);
            default:              r = ratio_t'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbdiv_sel_decode.sv
module fbdiv_sel_decode
    import fbdiv_pkg::*;
(
    input  logic [1:0] sel_hi_i,
    input  logic [1:0] sel_lo_i,
    output ratio_t     ratio_o,
    output logic       illegal_o
);

    always_comb begin
        illegal_o = (sel_hi_i == LVL_BAD) || (sel_lo_i == LVL_BAD);
        ratio_o   = illegal_o ? ratio_t'(1) : ratio_of(sel_hi_i, sel_lo_i);
    end

endmodule

// File: rtl/fbdiv_phase_gen.sv
module fbdiv_phase_gen
    import fbdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  ratio_t ratio_i,
    output ratio_t ratio_o,
    output logic   pos_o,
    output logic   load_o
);

    phase_st_t st_d, st_q;
    ratio_t    half;
    logic      wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.ratio <= ratio_t'(1)) || (st_q.cnt == st_q.ratio - ratio_t'(1));
        if (wrap) begin
            st_d.ratio = ratio_i;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt   = st_q.cnt + ratio_t'(1);
        end
        // Rising-edge phase: N/2 cycles for even N, (N-1)/2 cycles for odd N
        half     = st_d.ratio >> 1;
        st_d.pos = (st_d.ratio >= ratio_t'(2)) && (st_d.cnt < half);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ratio_o = st_q.ratio;
    assign pos_o   = st_q.pos;
    assign load_o  = wrap;

    // R1: the active ratio is always idle (0) or one of the nine legal ratios
    assert_ratio_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ratio inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd10, 4'd12});

    // R2: the position never runs past the active ratio
    assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ratio > ratio_t'(1)) |-> (st_q.cnt < st_q.ratio));

    // R8: the active ratio is held through the whole period
    assert_ratio_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> $stable(st_q.ratio));

    // R9: a high phase opens only at the start of a period
    assert_rise_at_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.pos) |-> (st_q.cnt == '0));

    // R7: state stays cleared while reset is held
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_reset_clear_R7: assert (st_q.cnt == '0 && !st_q.pos && st_q.ratio == '0);
        end
    end

endmodule

// File: rtl/fbdiv_half_delay.sv
module fbdiv_half_delay (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic phase_i,
    output logic phase_o
);

    logic dly_d, dly_q;

    always_comb begin
        dly_d = phase_i;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= 1'b0;
        else         dly_q <= dly_d;
    end

    assign phase_o = dly_q;

    // R3: the delayed copy at a falling edge equals the phase held during the high half
    assert_delay_tracks_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dly_q == $past(phase_i)));

endmodule

// File: rtl/fbk_clock_divider.sv
module fbk_clock_divider
    import fbdiv_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [1:0]         sel_hi_i,
    input  logic [1:0]         sel_lo_i,
    output logic [NUM_OUT-1:0] fbk_clk_o,
    output logic               illegal_sel_o
);

    ratio_t new_ratio;
    ratio_t act_ratio;
    logic   illegal;
    logic   pos_phase;
    logic   neg_phase;
    logic   load;
    logic   core_clk;

    fbdiv_sel_decode u_decode (
        .sel_hi_i  (sel_hi_i),
        .sel_lo_i  (sel_lo_i),
        .ratio_o   (new_ratio),
        .illegal_o (illegal)
    );

    fbdiv_phase_gen u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ratio_i (new_ratio),
        .ratio_o (act_ratio),
        .pos_o   (pos_phase),
        .load_o  (load)
    );

    fbdiv_half_delay u_delay (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (pos_phase),
        .phase_o (neg_phase)
    );

    always_comb begin
        if (act_ratio == ratio_t'(1))      core_clk = clk_i;
        else if (act_ratio == '0)          core_clk = 1'b0;
        else                               core_clk = pos_phase | (act_ratio[0] & neg_phase);
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign fbk_clk_o[g] = core_clk;
    end

    assign illegal_sel_o = illegal;

    // R5: a load while the code is illegal selects pass-through
    assert_illegal_forces_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (illegal && load) |=> (act_ratio == ratio_t'(1)));

endmodule

// File: tb/fbk_clock_divider_tb_top.sv
`timescale 1ns/100ps
module fbk_clock_divider_tb_top;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic [1:0] sel_hi = 2'b00;
    logic [1:0] sel_lo = 2'b00;
    logic [1:0] fbk;
    logic       illegal;

    int    checks = 0;
    int    fails  = 0;
    item_t q[$];

    always #5 clk = ~clk;

    fbk_clock_divider #(.NUM_OUT(2)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .sel_hi_i      (sel_hi),
        .sel_lo_i      (sel_lo),
        .fbk_clk_o     (fbk),
        .illegal_sel_o (illegal)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Expected ratio from the select codes (R1 table)
    function automatic int model_ratio(input logic [1:0] h, input logic [1:0] l);
        int tab[9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};
        if (h == 2'b11 || l == 2'b11) return 1;
        return tab[h * 3 + l];
    endfunction

    // Driver side: one item per half input period; high for the first n halves of 2n
    task automatic push_ratio(input int n, input int periods, input string tag);
        for (int p = 0; p < periods; p++)
            for (int s = 0; s < 2 * n; s++) begin
                item_t it;
                it.exp = (s < n);
                it.tag = tag;
                q.push_back(it);
            end
    endtask

    function automatic string tag_of(input int n);
        if (n == 1) return "R4 R1";
        if (n % 2 == 1) return "R3 R1 R9";
        return "R2 R1 R9";
    endfunction

    // Monitor: samples in the middle of each half period
    task automatic sample_once();
        item_t it;
        if (q.size() > 0) begin
            it = q.pop_front();
            chk(fbk[0], it.exp, it.tag);
            chk(fbk[1], fbk[0], "R6");
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #2.5; sample_once();
            @(negedge clk); #2.5; sample_once();
        end
    end

    task automatic do_reset(input logic [1:0] h, input logic [1:0] l);
        rst_n  = 1'b0;
        sel_hi = h;
        sel_lo = l;
        repeat (3) @(posedge clk);
        #2.5 chk(fbk[0], 1'b0, "R7");
        chk(fbk[1], 1'b0, "R7");
        @(negedge clk);
        #2.5 chk(fbk[0], 1'b0, "R7");
        #0.5 rst_n = 1'b1;
    endtask

    initial begin
        #1 rst_n = 1'b0;

        // Every ratio from reset, three full periods each
        for (int h = 0; h < 3; h++)
            for (int l = 0; l < 3; l++) begin
                int n;
                n = model_ratio(h[1:0], l[1:0]);
                do_reset(h[1:0], l[1:0]);
                push_ratio(n, 3, tag_of(n));
                chk(illegal, 1'b0, "R5");
                wait (q.size() == 0);
            end

        // Unused code on either select: flag set, pass-through
        do_reset(2'b11, 2'b01);
        push_ratio(1, 3, "R5");
        chk(illegal, 1'b1, "R5");
        wait (q.size() == 0);
        do_reset(2'b00, 2'b11);
        push_ratio(1, 3, "R5");
        chk(illegal, 1'b1, "R5");
        wait (q.size() == 0);

        // R8: select changes mid-period take effect only at period end
        do_reset(2'b01, 2'b00);                 // ratio 4
        push_ratio(4, 2, "R8");
        wait (q.size() == 6);
        sel_hi = 2'b00; sel_lo = 2'b10;         // ratio 3
        push_ratio(3, 2, "R8");
        wait (q.size() == 3);
        sel_hi = 2'b00; sel_lo = 2'b00;         // ratio 1
        push_ratio(1, 3, "R8");
        wait (q.size() == 1);
        sel_hi = 2'b01; sel_lo = 2'b01;         // ratio 5
        push_ratio(5, 2, "R8");
        wait (q.size() == 4);
        sel_hi = 2'b10; sel_lo = 2'b10;         // ratio 12
        push_ratio(12, 2, "R8");
        wait (q.size() == 0);

        // Reset in the middle of a run clears outputs at once
        @(posedge clk); #2.5;
        rst_n = 1'b0;
        #1 chk(fbk[0], 1'b0, "R7");
        chk(fbk[1], 1'b0, "R7");
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule